// File: doc/BRIEF.md
# Thermal Alarm Comparator with Fault Queue

This block watches a stream of signed temperature samples and drives a single alarm level. Each sample is compared against two programmable limits: an upper trip point and a lower release point. The alarm only changes after a programmable number of consecutive qualifying samples, so one noisy reading cannot flip it. Two trip modes are offered:

- **Comparator mode.** The alarm follows the temperature with a hysteresis band.
- **Interrupt mode.** The alarm is a latched event that a register read clears. Each time it trips, it re-arms for the opposite threshold crossing.

The temperature and both limits arrive as 16-bit register words. The signed value sits in the top 9 bits, at 0.5 °C per LSB. Configuration inputs select the mode, the qualifier depth and the output polarity, and carry a shutdown bit. While shutdown is set, incoming samples are ignored. A surrounding register file supplies the limit words and configuration, pulses `rd_pulse` when software reads a register, and takes `alarm_out` to a pad.

Top module: `thalm_alarm`

## Requirements
- R1: Only bits 15..7 of the sample and limit words take part in comparisons. They are treated as a 9-bit two's-complement value, and bits 6..0 have no effect.
- R2: In comparator mode (`cfg_irq_mode`=0) with the alarm inactive, a sample above the upper limit qualifies. Once the selected number of consecutive qualifying samples is reached, the alarm becomes active.
- R3: In comparator mode with the alarm active, only a sample below the lower limit qualifies. The alarm returns to inactive after the selected number of such samples. Samples between the limits keep it active.
- R4: A sample exactly equal to either limit never qualifies.
- R5: In interrupt mode (`cfg_irq_mode`=1), the alarm starts armed for an upper-limit crossing. Each trip sets the alarm and re-arms the detector for the opposite crossing, so the next trip after an over-temperature trip needs a sample below the lower limit, and vice versa.
- R6: In interrupt mode, a clock with `rd_pulse`=1 and no sample clears the alarm. In comparator mode, `rd_pulse` has no effect.
- R7: `cfg_queue_sel` selects the number of consecutive qualifying samples: 00=1, 01=2, 10=4, 11=6. A valid non-qualifying sample resets the count. Cycles without `smp_valid` neither add to the count nor reset it.
- R8: With `cfg_active_high`=1, `alarm_out` equals the alarm level. With `cfg_active_high`=0, it is inverted, so an active alarm drives 0.
- R9: While `cfg_shutdown`=1, samples are ignored and the qualifier count is held at zero. In comparator mode the alarm holds its level.
- R10: In interrupt mode, the rising edge of `cfg_shutdown` clears the alarm at the next clock.
- R11: A sample presented at a clock edge affects `alarm_out` only after that edge. The output is driven from registers.
- R12: After reset, the alarm level is inactive and the detector is armed for an upper-limit crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | One-cycle strobe marking a new temperature sample |
| smp_word | input | 16 | Temperature register word, value in bits 15..7 |
| lim_hi_word | input | 16 | Upper (trip) limit word, value in bits 15..7 |
| lim_lo_word | input | 16 | Lower (release) limit word, value in bits 15..7 |
| cfg_shutdown | input | 1 | Shutdown: ignore samples, clear count |
| cfg_irq_mode | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| cfg_active_high | input | 1 | Output polarity, 1 = active high |
| cfg_queue_sel | input | 2 | Consecutive-sample depth select |
| rd_pulse | input | 1 | Register-read strobe, clears a latched interrupt |
| alarm_out | output | 1 | Alarm level after polarity |

## Verification
Comparator mode is driven through a rising ramp and then a falling ramp. Both ramps touch each limit exactly, which separates a strict comparison from an inclusive one, and the falling ramp crosses the band between the limits, which separates hysteresis from a single threshold. Negative limits with a positive sample, and words whose ignored low bits would change an unsigned or full-word comparison, show that the value is taken as signed and from the right field. Interrupt mode is given repeated hot samples, reads and cold samples, which shows whether the detector re-arms for the opposite crossing rather than re-tripping. Qualifier runs are broken by one normal sample or padded with idle cycles, which tells a consecutive count from a cumulative one and a sample-based count from a cycle-based one.

// File: rtl/thalm_pkg.sv
package thalm_pkg;

  // Direction the detector is currently armed for.
  typedef enum logic {
    ARM_HOT  = 1'b0,
    ARM_COLD = 1'b1
  } arm_dir_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/thalm_rst_sync.sv
module thalm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/thalm_window_cmp.sv
module thalm_window_cmp #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned TEMP_W = 9
) (
  input  logic [WORD_W-1:0] sample_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  output logic              is_hot,
  output logic              is_cold
);

  localparam int unsigned FLD_LSB = WORD_W - TEMP_W;

  logic signed [TEMP_W-1:0] smp_val;
  logic signed [TEMP_W-1:0] hi_val;
  logic signed [TEMP_W-1:0] lo_val;
  logic                     unused_low_bits;

  assign smp_val = sample_word[WORD_W-1:FLD_LSB];
  assign hi_val  = hi_word[WORD_W-1:FLD_LSB];
  assign lo_val  = lo_word[WORD_W-1:FLD_LSB];

  // Fraction bits below the field are don't-care.
  assign unused_low_bits = ^{sample_word[FLD_LSB-1:0], hi_word[FLD_LSB-1:0], lo_word[FLD_LSB-1:0]};

  // Strict signed comparisons: equality never qualifies.
  assign is_hot  = (smp_val > hi_val);
  assign is_cold = (smp_val < lo_val);

endmodule

// File: rtl/thalm_fault_queue.sv
module thalm_fault_queue #(
  parameter int unsigned DEPTH0 = 1,
  parameter int unsigned DEPTH1 = 2,
  parameter int unsigned DEPTH2 = 4,
  parameter int unsigned DEPTH3 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_zero,
  input  logic       sample_en,
  input  logic       qualify,
  input  logic [1:0] depth_sel,
  output logic       trip
);

  localparam int unsigned MAX_DEPTH = thalm_pkg::max4(DEPTH0, DEPTH1, DEPTH2, DEPTH3);
  localparam int unsigned CNT_W     = $clog2(MAX_DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] depth_lim;
  logic             cnt_ce;

  always_comb begin
    unique case (depth_sel)
      2'b00:   depth_lim = CNT_W'(DEPTH0);
      2'b01:   depth_lim = CNT_W'(DEPTH1);
      2'b10:   depth_lim = CNT_W'(DEPTH2);
      default: depth_lim = CNT_W'(DEPTH3);
    endcase
  end

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    trip   = 1'b0;
    if (hold_zero) begin
      cnt_d  = '0;
      cnt_ce = 1'b1;
    end else if (sample_en) begin
      cnt_ce = 1'b1;
      if (!qualify) begin
        cnt_d = '0;
      end else if (cnt_inc >= depth_lim) begin
        trip  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/thalm_alarm_state.sv
module thalm_alarm_state
  import thalm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic is_hot,
  input  logic is_cold,
  input  logic irq_mode,
  input  logic shutdown,
  input  logic rd_pulse,
  output logic qualify,
  output logic alarm_lvl
);

  arm_dir_e dir_q;
  arm_dir_e dir_d;
  logic     dir_ce;
  logic     flag_q;
  logic     flag_d;
  logic     flag_ce;
  logic     sd_q;
  logic     sd_enter;

  assign qualify  = (dir_q == ARM_HOT) ? is_hot : is_cold;
  assign sd_enter = shutdown & ~sd_q;

  always_comb begin
    dir_ce = trip;
    dir_d  = (dir_q == ARM_HOT) ? ARM_COLD : ARM_HOT;
  end

  always_comb begin
    flag_ce = 1'b0;
    flag_d  = flag_q;
    if (irq_mode) begin
      if (trip) begin
        flag_ce = 1'b1;
        flag_d  = 1'b1;
      end else if (rd_pulse || sd_enter) begin
        flag_ce = 1'b1;
        flag_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= ARM_HOT;
      flag_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      if (dir_ce)  dir_q  <= dir_d;
      if (flag_ce) flag_q <= flag_d;
      sd_q <= shutdown;
    end
  end

  assign alarm_lvl = irq_mode ? flag_q : (dir_q == ARM_COLD);

endmodule

// File: rtl/thalm_alarm.sv
module thalm_alarm #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned TEMP_W      = 9,
  parameter int unsigned DEPTH0      = 1,
  parameter int unsigned DEPTH1      = 2,
  parameter int unsigned DEPTH2      = 4,
  parameter int unsigned DEPTH3      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_word,
  input  logic [WORD_W-1:0] lim_hi_word,
  input  logic [WORD_W-1:0] lim_lo_word,
  input  logic              cfg_shutdown,
  input  logic              cfg_irq_mode,
  input  logic              cfg_active_high,
  input  logic [1:0]        cfg_queue_sel,
  input  logic              rd_pulse,
  output logic              alarm_out
);

  logic rst_n_sync;
  logic is_hot;
  logic is_cold;
  logic qualify;
  logic trip;
  logic alarm_lvl;

  thalm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  thalm_window_cmp #(.WORD_W(WORD_W), .TEMP_W(TEMP_W)) u_cmp (
    .sample_word (smp_word),
    .hi_word     (lim_hi_word),
    .lo_word     (lim_lo_word),
    .is_hot      (is_hot),
    .is_cold     (is_cold)
  );

  thalm_fault_queue #(
    .DEPTH0 (DEPTH0), .DEPTH1 (DEPTH1), .DEPTH2 (DEPTH2), .DEPTH3 (DEPTH3)
  ) u_fq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .hold_zero (cfg_shutdown),
    .sample_en (smp_valid),
    .qualify   (qualify),
    .depth_sel (cfg_queue_sel),
    .trip      (trip)
  );

  thalm_alarm_state u_st (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .trip      (trip),
    .is_hot    (is_hot),
    .is_cold   (is_cold),
    .irq_mode  (cfg_irq_mode),
    .shutdown  (cfg_shutdown),
    .rd_pulse  (rd_pulse),
    .qualify   (qualify),
    .alarm_lvl (alarm_lvl)
  );

  assign alarm_out = cfg_active_high ? alarm_lvl : ~alarm_lvl;

endmodule

// File: rtl/thalm_checker.sv
module thalm_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned TEMP_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [WORD_W-1:0] smp_word,
  input logic [WORD_W-1:0] lim_hi_word,
  input logic [WORD_W-1:0] lim_lo_word,
  input logic              cfg_shutdown,
  input logic              cfg_irq_mode,
  input logic              rd_pulse,
  input logic              alarm_lvl
);

  localparam int unsigned FLD_LSB = WORD_W - TEMP_W;

  logic signed [TEMP_W-1:0] t_v, h_v, l_v;
  logic hot_c, cold_c;
  logic unused_chk_bits;

  assign t_v    = smp_word[WORD_W-1:FLD_LSB];
  assign h_v    = lim_hi_word[WORD_W-1:FLD_LSB];
  assign l_v    = lim_lo_word[WORD_W-1:FLD_LSB];
  assign hot_c  = t_v > h_v;
  assign cold_c = t_v < l_v;
  assign unused_chk_bits = ^{smp_word[FLD_LSB-1:0], lim_hi_word[FLD_LSB-1:0], lim_lo_word[FLD_LSB-1:0]};

  AST_COMP_RISE_NEEDS_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_mode && !$past(cfg_irq_mode) && $rose(alarm_lvl))
      |-> $past(smp_valid && !cfg_shutdown && hot_c)); // R2

  AST_COMP_FALL_NEEDS_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_mode && !$past(cfg_irq_mode) && $fell(alarm_lvl))
      |-> $past(smp_valid && !cfg_shutdown && cold_c)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_mode && !$past(cfg_irq_mode) && !$past(smp_valid))
      |-> $stable(alarm_lvl)); // R7

  AST_SHUTDOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_mode && !$past(cfg_irq_mode) && $past(cfg_shutdown))
      |-> $stable(alarm_lvl)); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irq_mode && $past(cfg_irq_mode && rd_pulse && !smp_valid))
      |-> !alarm_lvl); // R6

  AST_SD_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irq_mode && $rose(cfg_shutdown))
      |=> (!cfg_irq_mode || !alarm_lvl)); // R10

endmodule

bind thalm_alarm thalm_checker #(.WORD_W(WORD_W), .TEMP_W(TEMP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .smp_valid    (smp_valid),
  .smp_word     (smp_word),
  .lim_hi_word  (lim_hi_word),
  .lim_lo_word  (lim_lo_word),
  .cfg_shutdown (cfg_shutdown),
  .cfg_irq_mode (cfg_irq_mode),
  .rd_pulse     (rd_pulse),
  .alarm_lvl    (alarm_lvl)
);

// File: tb/tb_thalm_alarm.sv
`timescale 1ns/1ps
module tb_thalm_alarm;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_word;
  logic [15:0] lim_hi_word;
  logic [15:0] lim_lo_word;
  logic        cfg_shutdown;
  logic        cfg_irq_mode;
  logic        cfg_active_high;
  logic [1:0]  cfg_queue_sel;
  logic        rd_pulse;
  logic        alarm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  thalm_alarm dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .smp_valid       (smp_valid),
    .smp_word        (smp_word),
    .lim_hi_word     (lim_hi_word),
    .lim_lo_word     (lim_lo_word),
    .cfg_shutdown    (cfg_shutdown),
    .cfg_irq_mode    (cfg_irq_mode),
    .cfg_active_high (cfg_active_high),
    .cfg_queue_sel   (cfg_queue_sel),
    .rd_pulse        (rd_pulse),
    .alarm_out       (alarm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] mkw(input int t, input logic [6:0] junk);
    logic [8:0] v;
    v = t[8:0];
    return {v, junk};
  endfunction

  task automatic chk(input logic exp, input string req);
    n_cmp++;
    if (alarm_out !== exp) begin
      n_bad++;
      $display("FAIL %s: alarm_out=%b expected %b", req, alarm_out, exp);
    end
  endtask

  task automatic do_reset(input logic irq, input logic ah, input logic [1:0] qs,
                          input int hi, input int lo);
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; rd_pulse = 1'b0; cfg_shutdown = 1'b0;
    smp_word = '0;
    cfg_irq_mode = irq; cfg_active_high = ah; cfg_queue_sel = qs;
    lim_hi_word = mkw(hi, 7'h00); lim_lo_word = mkw(lo, 7'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic samp_j(input int t, input logic [6:0] junk);
    @(negedge clk);
    smp_valid = 1'b1; smp_word = mkw(t, junk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic samp(input int t);
    samp_j(t, 7'h5A);
  endtask

  task automatic rd;
    @(negedge clk); rd_pulse = 1'b1;
    @(negedge clk); rd_pulse = 1'b0;
  endtask

  task automatic set_sd(input logic v);
    @(negedge clk); cfg_shutdown = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b1, 2'b00, 160, 150);
    chk(1'b0, "R12 reset inactive (active high)");
    do_reset(1'b0, 1'b0, 2'b00, 160, 150);
    chk(1'b1, "R12/R8 reset inactive shows 1 when active low");
  endtask

  task automatic t_comp_basic;
    do_reset(1'b0, 1'b1, 2'b00, 160, 150);
    samp(150);  chk(1'b0, "R2 below trip");
    samp(160);  chk(1'b0, "R4 equal to upper limit");
    // R11: output still old just before the capturing edge
    @(negedge clk); smp_valid = 1'b1; smp_word = mkw(161, 7'h11);
    #1; chk(1'b0, "R11 no change before edge");
    @(negedge clk); smp_valid = 1'b0;
    chk(1'b1, "R2 above upper limit trips");
    rd;         chk(1'b1, "R6 read ignored in comparator mode");
    samp(155);  chk(1'b1, "R3 inside band holds");
    samp(150);  chk(1'b1, "R4 equal to lower limit");
    samp(149);  chk(1'b0, "R3 below lower limit releases");
    samp(155);  chk(1'b0, "R3 band keeps released");
  endtask

  task automatic t_field;
    do_reset(1'b0, 1'b1, 2'b00, 160, 150);
    samp_j(160, 7'h7F); chk(1'b0, "R1 low bits ignored on sample");
    do_reset(1'b0, 1'b1, 2'b00, -20, -40);
    samp(-25); chk(1'b0, "R1 signed below negative limit");
    samp(-10); chk(1'b1, "R1 signed above negative limit");
    samp(-40); chk(1'b1, "R1/R4 equal negative lower limit");
    samp(-41); chk(1'b0, "R1 signed below negative lower limit");
    samp(100); chk(1'b1, "R1 positive beats negative limit");
  endtask

  task automatic t_queue;
    do_reset(1'b0, 1'b1, 2'b01, 160, 150);
    samp(170); chk(1'b0, "R7 depth2 after one");
    samp(170); chk(1'b1, "R7 depth2 after two");
    do_reset(1'b0, 1'b1, 2'b10, 160, 150);
    for (int i = 0; i < 3; i++) samp(170);
    samp(155);
    for (int i = 0; i < 3; i++) begin samp(170); repeat (3) @(negedge clk); end
    chk(1'b0, "R7 depth4 count broken by normal sample");
    samp(170); chk(1'b1, "R7 depth4 reached across idle cycles");
    do_reset(1'b0, 1'b1, 2'b11, 160, 150);
    for (int i = 0; i < 5; i++) samp(170);
    chk(1'b0, "R7 depth6 after five");
    samp(170); chk(1'b1, "R7 depth6 after six");
  endtask

  task automatic t_irq;
    do_reset(1'b1, 1'b1, 2'b00, 160, 150);
    samp(155); chk(1'b0, "R5 band sample no event");
    samp(170); chk(1'b1, "R5 hot trip sets");
    samp(170); chk(1'b1, "R5 stays until read");
    rd;        chk(1'b0, "R6 read clears");
    samp(170); chk(1'b0, "R5 hot not armed after hot trip");
    samp(150); chk(1'b0, "R4 equal lower in interrupt mode");
    samp(140); chk(1'b1, "R5 cold crossing trips");
    rd;        chk(1'b0, "R6 read clears cold event");
    samp(140); chk(1'b0, "R5 cold not armed after cold trip");
    samp(170); chk(1'b1, "R5 hot re-armed");
  endtask

  task automatic t_polarity;
    do_reset(1'b0, 1'b0, 2'b00, 160, 150);
    samp(170); chk(1'b0, "R8 active low asserted drives 0");
    samp(100); chk(1'b1, "R8 active low released drives 1");
  endtask

  task automatic t_shutdown;
    do_reset(1'b0, 1'b1, 2'b01, 160, 150);
    samp(170);
    set_sd(1'b1);
    samp(170); samp(170); chk(1'b0, "R9 samples ignored in shutdown");
    set_sd(1'b0);
    samp(170); chk(1'b0, "R9 count restarted after shutdown");
    samp(170); chk(1'b1, "R9 trips after full count");
    set_sd(1'b1);
    samp(100); samp(100); chk(1'b1, "R9 comparator level holds in shutdown");
    set_sd(1'b0);
    do_reset(1'b1, 1'b1, 2'b00, 160, 150);
    samp(170); chk(1'b1, "R10 interrupt set before shutdown");
    set_sd(1'b1); chk(1'b0, "R10 entering shutdown clears");
    set_sd(1'b0);
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; rd_pulse = 1'b0; cfg_shutdown = 1'b0;
    cfg_irq_mode = 1'b0; cfg_active_high = 1'b1; cfg_queue_sel = 2'b00;
    smp_word = '0; lim_hi_word = '0; lim_lo_word = '0;
    t_reset;
    t_comp_basic;
    t_field;
    t_queue;
    t_irq;
    t_polarity;
    t_shutdown;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule